// File: doc/BRIEF.md
# Symmetric Up-Down PWM Timer

This block is an 8-bit pulse-width modulator built around a counter that climbs from zero to a programmable ceiling and then falls back to zero. Each full climb-and-fall forms one period, so the pulse it produces is centred on the ceiling. Software loads a duty value and a ceiling value through a single-cycle write port. Neither value acts at once: each sits in a shadow register until a commit point in the count, so a period is never cut short and never produces a glitch.

The `mode` input picks the commit point. With `mode` = 0 (centre-aligned), both shadows move into the active registers on the cycle the counter sits at its ceiling. A new duty value is therefore first compared at ceiling-1 on the way down. With `mode` = 1 (period-symmetric), both shadows commit on the cycle the count is zero, so every period has equal rising and falling halves even when the ceiling changes.

The counter is a two-state machine. In `RAMP_UP` it increments. The transition `RAMP_UP -> RAMP_DOWN` fires when the count reaches or passes the active ceiling, and the count then steps down by one. In `RAMP_DOWN` it decrements. The transition `RAMP_DOWN -> RAMP_UP` fires at count zero, and the count then steps to one. A ceiling of zero is a special case: `RAMP_UP` stays put and the count holds at zero.

Top module: `pwm_pc_timer`

## Requirements
- R1: After reset the count is 0, the output is low, the active and shadow duty values are 0, and the active and shadow ceilings are 255; the first ramp therefore peaks at 255.
- R2: With a ceiling C ≥ 1 the count follows 0,1,…,C,C-1,…,1,0,1,… and changes by exactly one per cycle.
- R3: A write with `wr_en`=1 loads `wr_data` into the duty shadow when `wr_sel`=0 and into the ceiling shadow when `wr_sel`=1.
- R4: With `mode`=0 the duty shadow is committed on the clock edge where the count equals the ceiling while rising; a new duty value first matches at ceiling-1 while falling, and never on the rising half before that edge.
- R5: With `mode`=1 both shadows are committed on the clock edge where the count is 0; a ceiling written while falling sets the peak of the following ramp only.
- R6: With `mode`=0 the ceiling shadow is committed on the same edge as the duty shadow.
- R7: When the active duty value D satisfies 0 < D < ceiling, `pwm_out` goes low the cycle after a match while rising and high the cycle after a match while falling.
- R8: An active duty value of 0 keeps `pwm_out` low; an active duty value at or above the active ceiling keeps it high (from the cycle after the value is active).
- R9: `cmp_hit` is high exactly in the cycles where the count equals the active duty value.
- R10: `period_evt` is high in cycles where the count is 0, or the count is at the ceiling while rising.
- R11: An active ceiling of 0 holds the count at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = commit at ceiling, 1 = commit at zero |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_sel | input | 1 | 0 = duty shadow, 1 = ceiling shadow |
| wr_data | input | 8 | Value to write |
| count | output | 8 | Current counter value |
| pwm_out | output | 1 | Registered PWM waveform |
| cmp_hit | output | 1 | Count equals active duty value |
| period_evt | output | 1 | Count is at ceiling (rising) or at zero |

## Verification
Some properties are checked by the assertions on every cycle:
- the count moves by at most one per cycle;
- the active duty value changes only at zero or at the ceiling;
- the output stays low under a zero duty value, high under a saturated one, and rises only after a falling match;
- a zero ceiling freezes the count.

Other behaviour only the directed scenarios can show:
- on which exact falling step a freshly written duty value first matches;
- that a ceiling written mid-fall in period-symmetric mode shapes only the next ramp;
- the peak of 255 after reset.

The bench checks these against a cycle model written from the requirements.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;
    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_e;

    localparam logic SEL_DUTY = 1'b0;
    localparam logic SEL_CEIL = 1'b1;
endpackage

// File: rtl/pwm_ramp_fsm.sv
module pwm_ramp_fsm
    import pwm_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] top_act,
    output logic [W-1:0] count,
    output ramp_e        state,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    ramp_e        state_nxt;
    logic [W-1:0] count_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RAMP_UP;
            count <= ZERO;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        count_nxt = count;
        unique case (state)
            RAMP_UP: begin
                if (count >= top_act) begin
                    if (top_act == ZERO && count == ZERO) begin
                        count_nxt = ZERO;
                    end else begin
                        state_nxt = RAMP_DOWN;
                        count_nxt = count - ONE;
                    end
                end else begin
                    count_nxt = count + ONE;
                end
            end
            RAMP_DOWN: begin
                if (count == ZERO) begin
                    state_nxt = RAMP_UP;
                    count_nxt = (top_act == ZERO) ? ZERO : ONE;
                end else begin
                    count_nxt = count - ONE;
                end
            end
        endcase
    end

    assign at_top    = (state == RAMP_UP) && (count >= top_act);
    assign at_bottom = (count == ZERO);
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         at_top,
    input  logic         at_bottom,
    output logic [W-1:0] cmp_act,
    output logic [W-1:0] top_act
);
    logic [W-1:0] cmp_buf;
    logic [W-1:0] top_buf;
    logic         commit;

    assign commit = mode ? at_bottom : at_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf <= '0;
            top_buf <= '1;
        end else if (wr_en) begin
            if (wr_sel == SEL_DUTY) cmp_buf <= wr_data;
            else                    top_buf <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_act <= '0;
            top_act <= '1;
        end else if (commit) begin
            cmp_act <= cmp_buf;
            top_act <= top_buf;
        end
    end
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
    import pwm_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ramp_e        state,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_act,
    input  logic [W-1:0] top_act,
    output logic         pwm_out,
    output logic         cmp_hit
);
    logic pwm_nxt;

    assign cmp_hit = (count == cmp_act);

    always_comb begin
        pwm_nxt = pwm_out;
        if (cmp_act == '0)              pwm_nxt = 1'b0;
        else if (cmp_act >= top_act)    pwm_nxt = 1'b1;
        else if (cmp_hit) begin
            unique case (state)
                RAMP_UP:   pwm_nxt = 1'b0;
                RAMP_DOWN: pwm_nxt = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= pwm_nxt;
    end
endmodule

// File: rtl/pwm_pc_timer.sv
module pwm_pc_timer
    import pwm_pc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         pwm_out,
    output logic         cmp_hit,
    output logic         period_evt
);
    ramp_e        state;
    logic         at_top;
    logic         at_bottom;
    logic [W-1:0] cmp_act;
    logic [W-1:0] top_act;

    pwm_ramp_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .top_act   (top_act),
        .count     (count),
        .state     (state),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    pwm_shadow_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .cmp_act   (cmp_act),
        .top_act   (top_act)
    );

    pwm_wave_gen #(.W(W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .count   (count),
        .cmp_act (cmp_act),
        .top_act (top_act),
        .pwm_out (pwm_out),
        .cmp_hit (cmp_hit)
    );

    assign period_evt = at_top | at_bottom;
endmodule

// File: rtl/pwm_pc_timer_chk.sv
module pwm_pc_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] count,
    input logic         pwm_out,
    input logic         cmp_hit,
    input logic [W-1:0] cmp_act,
    input logic [W-1:0] top_act
);
    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + W'(1)) ||
        ($past(count) == count + W'(1)));

    // R4
    duty_commit_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act != $past(cmp_act)) |->
        (($past(count) == '0) || ($past(count) >= $past(top_act))));

    // R8
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_act) == '0) |-> !pwm_out);

    // R8
    full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cmp_act) != '0) && ($past(cmp_act) >= $past(top_act))) |-> pwm_out);

    // R7
    rise_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> ($past(cmp_hit) || ($past(cmp_act) >= $past(top_act))));

    // R11
    zero_ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_act == '0) && (count == '0)) |=> (count == '0));
endmodule

bind pwm_pc_timer pwm_pc_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .pwm_out (pwm_out),
    .cmp_hit (cmp_hit),
    .cmp_act (cmp_act),
    .top_act (top_act)
);

// File: tb/pwm_pc_timer_test.sv
module pwm_pc_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count;
    logic       pwm_out;
    logic       cmp_hit;
    logic       period_evt;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    pwm_pc_timer uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count(count), .pwm_out(pwm_out),
        .cmp_hit(cmp_hit), .period_evt(period_evt)
    );

    always #2.5 clk = ~clk;

    // Reference model built from the requirements
    logic [7:0] m_cnt, m_cmpb, m_topb, m_cmpa, m_topa;
    logic       m_up, m_pwm;

    always @(posedge clk) begin
        logic at_t, at_b, commit, hit;
        logic [7:0] n_cnt;
        logic n_up, n_pwm;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_cmpb = 0; m_topb = 8'hFF;
            m_cmpa = 0; m_topa = 8'hFF; m_pwm = 0;
        end else begin
            at_t = m_up && (m_cnt >= m_topa);
            at_b = (m_cnt == 0);
            commit = mode ? at_b : at_t;
            hit = (m_cnt == m_cmpa);
            n_pwm = m_pwm;
            if (m_cmpa == 0) n_pwm = 0;
            else if (m_cmpa >= m_topa) n_pwm = 1;
            else if (hit) n_pwm = !m_up;
            n_up = m_up; n_cnt = m_cnt;
            if (m_up) begin
                if (m_cnt >= m_topa) begin
                    if (!(m_topa == 0 && m_cnt == 0)) begin n_up = 0; n_cnt = m_cnt - 1; end
                end else n_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin n_up = 1; n_cnt = (m_topa == 0) ? 0 : 1; end
                else n_cnt = m_cnt - 1;
            end
            if (commit) begin m_cmpa = m_cmpb; m_topa = m_topb; end
            if (wr_en) begin
                if (wr_sel) m_topb = wr_data; else m_cmpb = wr_data;
            end
            m_cnt = n_cnt; m_up = n_up; m_pwm = n_pwm;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Continuous comparison against the model, tagged with the current scenario
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "count", count, m_cnt);
            check(cur_req, "pwm_out", pwm_out, m_pwm);
            check("R9", "cmp_hit", cmp_hit, m_cnt == m_cmpa);
            check("R10", "period_evt", period_evt,
                  (m_up && m_cnt >= m_topa) || (m_cnt == 0));
        end
    end

    task automatic write_reg(input logic sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cur_req = "R1";
        rst_n = 0;
        idle(3);
        rst_n = 1;
        #1;
        check("R1", "count after reset", count, 0);
        check("R1", "pwm after reset", pwm_out, 0);
        check("R9", "hit at duty 0", cmp_hit, 1);
        check("R10", "evt at zero", period_evt, 1);
    endtask

    task automatic t_free_run;
        int peak = 0;
        cur_req = "R2 R3 R7";
        write_reg(1'b0, 8'd100);
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            if (count > peak) peak = count;
        end
        check("R1", "first peak", peak, 255);
    endtask

    task automatic t_pc_commit;
        logic [7:0] prev;
        cur_req = "R4 R6";
        mode = 0;
        write_reg(1'b1, 8'd20);
        write_reg(1'b0, 8'd10);
        idle(600);
        prev = count;
        @(negedge clk);
        while (!(count == 5 && prev == 4)) begin prev = count; @(negedge clk); end
        wr_en = 1; wr_sel = 0; wr_data = 8'd19;
        @(negedge clk);
        wr_en = 0;
        while (count != 19) @(negedge clk);
        check("R4", "no hit rising at 19", cmp_hit, 0);
        @(negedge clk);
        check("R6", "peak at ceiling 20", count, 20);
        @(negedge clk);
        check("R4", "count falling", count, 19);
        check("R4", "first hit at ceiling-1 falling", cmp_hit, 1);
        @(negedge clk);
        check("R7", "pwm set after falling match", pwm_out, 1);
    endtask

    task automatic t_pfc;
        logic [7:0] prev;
        int peak = 0;
        cur_req = "R5";
        mode = 1;
        write_reg(1'b1, 8'd40);
        write_reg(1'b0, 8'd15);
        idle(200);
        prev = count;
        @(negedge clk);
        while (!(count == 30 && prev == 31)) begin prev = count; @(negedge clk); end
        write_reg(1'b1, 8'd12);
        while (count != 0) @(negedge clk);
        @(negedge clk);
        while (count != 0) begin
            if (count > peak) peak = count;
            @(negedge clk);
        end
        check("R5", "peak after bottom commit", peak, 12);
        idle(60);
    endtask

    task automatic t_extremes;
        int bad;
        cur_req = "R8";
        mode = 0;
        write_reg(1'b1, 8'd30);
        write_reg(1'b0, 8'd0);
        idle(130);
        bad = 0;
        for (int i = 0; i < 70; i++) begin @(negedge clk); if (pwm_out) bad++; end
        check("R8", "high cycles with duty 0", bad, 0);
        write_reg(1'b0, 8'd30);
        idle(130);
        bad = 0;
        for (int i = 0; i < 70; i++) begin @(negedge clk); if (!pwm_out) bad++; end
        check("R8", "low cycles with duty at ceiling", bad, 0);
    endtask

    task automatic t_top_zero;
        int moved = 0;
        cur_req = "R11";
        mode = 0;
        write_reg(1'b1, 8'd0);
        idle(100);
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (count != 0) moved++; end
        check("R11", "count moves with ceiling 0", moved, 0);
        mode = 1;
        write_reg(1'b1, 8'd5);
        moved = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (count != 0) moved++; end
        check("R5", "ramp resumes after bottom commit", moved > 0, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_free_run();
        t_pc_commit();
        t_pfc();
        t_extremes();
        t_top_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule